// File: doc/BRIEF.md
# Bicubic Patch Midpoint Subdivider

This block takes the sixteen control nodes of a bicubic polynomial surface patch and splits the patch at the parameter midpoint in both directions. It produces the four control nets that together describe the same surface. Each node carries three signed fixed-point coordinates in Q8.10 form. The split uses repeated pairwise averaging, so the datapath is built only from adders and wired one-bit right shifts. All 64 output nodes are formed in parallel in a single calculation cycle.

A processor fills the input bank with one node per write access. It issues a start strobe and then fetches the results with one read access per node, 64 in all. The next net can be loaded while the previous results are still being fetched. A three-phase control machine sequences filling, calculating and draining.

Top module: `patch_midsplit`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `rd_valid` and `rd_err` are low, `rd_data` is zero and no result set is held.
- R2: A write stores `wr_data` as node `wr_addr`, where address = 4*i + j, i is the first (u) parameter index in bits [3:2] and j is the second (v) index in bits [1:0]. Within a node, x occupies bits [17:0], y occupies [35:18] and z occupies [53:36]. Writing an address again replaces the node it holds.
- R3: A start strobe is accepted only when each of the 16 addresses has been written at least once since the last accepted start. Any other start is ignored and `busy` stays low.
- R4: An accepted start raises `busy` for exactly one cycle. `done` rises in the cycle that follows, and a further 16 writes are needed before the next start.
- R5: Each coordinate is widened with two zero guard bits and split first along u and then along v. Each halving takes the floor of half the sum of two values. The result is truncated by floor-shifting out the guard bits.
- R6: Results are read in sub-patch order 0 to 3. Sub-patch 0 is low-u/low-v, 1 is low-u/high-v, 2 is high-u/low-v and 3 is high-u/high-v. Within a sub-patch the nodes come row-major with the u index major, in the same node layout as R2.
- R7: A read (`rd_en` while not busy) yields `rd_valid` and the next node on `rd_data` one cycle later. The read position then advances by one.
- R8: A read issued after the 64th node, or before any calculation has finished, returns zero and sets `rd_err`. `rd_err` stays set until the next calculation completes.
- R9: `done` stays high until the first read after the calculation and falls one cycle after that read.
- R10: Writes and reads in the `busy` cycle are ignored, and so is a write in the cycle where a start is accepted. A read in that same cycle is served from the previous result set.
- R11: Writes during draining go into the input bank without disturbing the results being read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Node write strobe |
| wr_addr | input | 4 | Input node address (u index in [3:2], v index in [1:0]) |
| wr_data | input | 54 | Node {z, y, x}, 18 bits each |
| start | input | 1 | Request a subdivision of the loaded net |
| rd_en | input | 1 | Result read strobe |
| rd_data | output | 54 | Result node {z, y, x}, registered |
| rd_valid | output | 1 | `rd_data` holds the answer to the previous read |
| busy | output | 1 | Calculation cycle in progress |
| done | output | 1 | New results ready and not yet read |
| rd_err | output | 1 | A read went past the last result |

## Verification
The interesting collisions are a start strobe that shares its cycle with a node write and a result read, and reads that interleave with writes for the next net. The bench drives a start, a write and a read together while it drains a net. Then it tries a read and a write in the busy cycle. A behavioural de Casteljau model of the bench decides each cycle whether every operation takes effect. It compares `busy`, `done`, `rd_valid`, `rd_err` and `rd_data` on every clock, so a dropped write or a read served from the wrong result set shows up as a mismatch.

// File: rtl/pms_pkg.sv
package pms_pkg;
  localparam int SIDE        = 4;
  localparam int IN_NODES    = SIDE * SIDE;
  localparam int SUB_PATCHES = 4;
  localparam int OUT_NODES   = IN_NODES * SUB_PATCHES;
  localparam int AXES        = 3;
  localparam int ADDR_W      = $clog2(IN_NODES);
  localparam int PTR_W       = $clog2(OUT_NODES) + 1;

  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,
    ST_CALC  = 2'd1,
    ST_DRAIN = 2'd2
  } pms_state_e;
endpackage

// File: rtl/pms_split4.sv
// Cubic curve split at t = 1/2 by three levels of pairwise averaging.
// q[0..3] is the low half, q[4..7] the high half.
module pms_split4 #(
  parameter int W = 20
) (
  input  logic [4*W-1:0] p,
  output logic [8*W-1:0] q
);
  function automatic logic [W-1:0] avg(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    s = {a[W-1], a} + {b[W-1], b};
    return s[W:1];
  endfunction

  logic [W-1:0] a0, a1, a2, a3;
  logic [W-1:0] m01, m12, m23, m012, m123, mid;

  assign a0   = p[0*W +: W];
  assign a1   = p[1*W +: W];
  assign a2   = p[2*W +: W];
  assign a3   = p[3*W +: W];
  assign m01  = avg(a0, a1);
  assign m12  = avg(a1, a2);
  assign m23  = avg(a2, a3);
  assign m012 = avg(m01, m12);
  assign m123 = avg(m12, m23);
  assign mid  = avg(m012, m123);

  assign q = {a3, m23, m123, mid, mid, m012, m01, a0};
endmodule

// File: rtl/pms_coord_net.sv
// One coordinate of the full 4x4 -> 4 x (4x4) midpoint split.
module pms_coord_net import pms_pkg::*; #(
  parameter int CW    = 18,
  parameter int GUARD = 2
) (
  input  logic [IN_NODES*CW-1:0]  src,
  output logic [OUT_NODES*CW-1:0] dst
);
  localparam int EW = CW + GUARD;

  logic [EW-1:0]     ext  [IN_NODES];
  logic [8*EW-1:0]   ucol [SIDE];
  logic [EW-1:0]     umid [2*SIDE*SIDE];
  logic [8*EW-1:0]   vrow [2*SIDE];

  genvar k, j, r, s, i, c;

  generate
    for (k = 0; k < IN_NODES; k++) begin : g_ext
      assign ext[k] = {src[k*CW +: CW], {GUARD{1'b0}}};
    end

    // first pass: along u, one column per v index
    for (j = 0; j < SIDE; j++) begin : g_u
      pms_split4 #(.W(EW)) u_split (
        .p ({ext[3*SIDE+j], ext[2*SIDE+j], ext[SIDE+j], ext[j]}),
        .q (ucol[j])
      );
      for (r = 0; r < 2*SIDE; r++) begin : g_umid
        assign umid[r*SIDE+j] = ucol[j][r*EW +: EW];
      end
    end

    // second pass: along v, one row per u position of both halves
    for (r = 0; r < 2*SIDE; r++) begin : g_v
      pms_split4 #(.W(EW)) u_split (
        .p ({umid[r*SIDE+3], umid[r*SIDE+2], umid[r*SIDE+1], umid[r*SIDE]}),
        .q (vrow[r])
      );
    end

    // gather sub-patch order, drop guard bits (floor)
    for (s = 0; s < SUB_PATCHES; s++) begin : g_sub
      for (i = 0; i < SIDE; i++) begin : g_row
        for (c = 0; c < SIDE; c++) begin : g_col
          localparam int RR = (s / 2) * SIDE + i;
          localparam int CC = (s % 2) * SIDE + c;
          localparam int OI = s * IN_NODES + i * SIDE + c;
          assign dst[OI*CW +: CW] = vrow[RR][CC*EW+GUARD +: CW];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pms_ctrl.sv
module pms_ctrl import pms_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              start,
  input  logic              rd_en,
  output logic              wr_ok,
  output logic              rd_ok,
  output logic              busy,
  output logic              done,
  output logic              rd_valid,
  output logic              rd_err,
  output logic              ptr_end,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [IN_NODES-1:0] load_mask
);
  pms_state_e state;
  logic       start_ok;

  assign busy     = (state == ST_CALC);
  assign ptr_end  = (rd_ptr == PTR_W'(OUT_NODES));
  assign start_ok = start && !busy && (&load_mask);
  assign wr_ok    = wr_en && !busy && !start_ok;
  assign rd_ok    = rd_en && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_FILL;
      load_mask <= '0;
      rd_ptr    <= PTR_W'(OUT_NODES);
      done      <= 1'b0;
      rd_valid  <= 1'b0;
      rd_err    <= 1'b0;
    end else begin
      rd_valid <= rd_ok;
      if (rd_ok) begin
        done <= 1'b0;
        if (ptr_end) rd_err <= 1'b1;
        else         rd_ptr <= rd_ptr + 1'b1;
      end

      unique case (state)
        ST_FILL: if (start_ok) state <= ST_CALC;
        ST_CALC: begin
          state  <= ST_DRAIN;
          rd_ptr <= '0;
          done   <= 1'b1;
          rd_err <= 1'b0;
        end
        ST_DRAIN: begin
          if (start_ok) state <= ST_CALC;
          else if (rd_ok && rd_ptr == PTR_W'(OUT_NODES - 1)) state <= ST_FILL;
        end
        default: state <= ST_FILL;
      endcase

      if (start_ok)   load_mask <= '0;
      else if (wr_ok) load_mask[wr_addr] <= 1'b1;
    end
  end
endmodule

// File: rtl/patch_midsplit.sv
module patch_midsplit import pms_pkg::*; #(
  parameter int COORD_W = 18,
  parameter int GUARD_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [AXES*COORD_W-1:0] wr_data,
  input  logic                    start,
  input  logic                    rd_en,
  output logic [AXES*COORD_W-1:0] rd_data,
  output logic                    rd_valid,
  output logic                    busy,
  output logic                    done,
  output logic                    rd_err
);
  localparam int NW = AXES * COORD_W;

  logic                wr_ok, rd_ok, ptr_end;
  logic [PTR_W-1:0]    rd_ptr;
  logic [IN_NODES-1:0] load_mask;

  logic [NW-1:0] in_mem  [IN_NODES];
  logic [NW-1:0] out_mem [OUT_NODES];

  logic [IN_NODES*COORD_W-1:0]  src [AXES];
  logic [OUT_NODES*COORD_W-1:0] dst [AXES];

  pms_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .start     (start),
    .rd_en     (rd_en),
    .wr_ok     (wr_ok),
    .rd_ok     (rd_ok),
    .busy      (busy),
    .done      (done),
    .rd_valid  (rd_valid),
    .rd_err    (rd_err),
    .ptr_end   (ptr_end),
    .rd_ptr    (rd_ptr),
    .load_mask (load_mask)
  );

  always_ff @(posedge clk) begin
    if (wr_ok) in_mem[wr_addr] <= wr_data;
  end

  genvar a, k;
  generate
    for (a = 0; a < AXES; a++) begin : g_axis
      for (k = 0; k < IN_NODES; k++) begin : g_src
        assign src[a][k*COORD_W +: COORD_W] = in_mem[k][a*COORD_W +: COORD_W];
      end
      pms_coord_net #(.CW(COORD_W), .GUARD(GUARD_W)) u_net (
        .src (src[a]),
        .dst (dst[a])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (busy) begin
      for (int o = 0; o < OUT_NODES; o++) begin
        for (int x = 0; x < AXES; x++) begin
          out_mem[o][x*COORD_W +: COORD_W] <= dst[x][o*COORD_W +: COORD_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_ok) rd_data <= ptr_end ? '0 : out_mem[rd_ptr[PTR_W-2:0]];
  end
endmodule

// File: rtl/pms_checker.sv
module pms_checker import pms_pkg::*; (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic                rd_en,
  input logic                busy,
  input logic                done,
  input logic                rd_valid,
  input logic                rd_err,
  input logic                rd_data_zero,
  input logic [PTR_W-1:0]    rd_ptr,
  input logic [IN_NODES-1:0] load_mask
);
  AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (rst) busy |=> !busy); // R4
  AST_DONE_AFTER_CALC: assert property (@(posedge clk) disable iff (rst) busy |=> done); // R4
  AST_START_GATED: assert property (@(posedge clk) disable iff (rst) (start && !busy && !(&load_mask)) |=> !busy); // R3
  AST_MASK_EMPTY_BUSY: assert property (@(posedge clk) disable iff (rst) busy |-> (load_mask == '0)); // R10
  AST_NO_READ_BUSY: assert property (@(posedge clk) disable iff (rst) (rd_en && busy) |=> !rd_valid); // R10
  AST_OVERRUN_ZERO: assert property (@(posedge clk) disable iff (rst) (rd_en && !busy && rd_ptr == PTR_W'(OUT_NODES)) |=> (rd_valid && rd_err && rd_data_zero)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) (rd_err && !busy) |=> rd_err); // R8
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst) (rd_en && !busy) |=> !done); // R9
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst) rd_ptr <= PTR_W'(OUT_NODES)); // R7
endmodule

bind patch_midsplit pms_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .rd_en        (rd_en),
  .busy         (busy),
  .done         (done),
  .rd_valid     (rd_valid),
  .rd_err       (rd_err),
  .rd_data_zero (rd_data == '0),
  .rd_ptr       (rd_ptr),
  .load_mask    (load_mask)
);

// File: tb/patch_midsplit_test.sv
module patch_midsplit_test;
  localparam int CW = 18;
  localparam int NW = 3 * CW;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en, start, rd_en;
  logic [3:0]    wr_addr;
  logic [NW-1:0] wr_data;
  logic [NW-1:0] rd_data;
  logic          rd_valid, busy, done, rd_err;

  always #10 clk = ~clk;

  patch_midsplit uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .busy(busy), .done(done), .rd_err(rd_err)
  );

  int    checks = 0;
  int    fails  = 0;
  string req    = "R1";
  bit    finished = 1'b0;

  // reference state
  logic [NW-1:0] m_in  [16];
  logic [NW-1:0] m_out [64];
  logic [15:0]   m_mask;
  int            m_ptr;
  bit            m_busy, m_done, m_valid, m_err;
  logic [NW-1:0] m_data;

  function automatic int sx(input logic [CW-1:0] v);
    logic signed [CW-1:0] t;
    t = v;
    return int'(t);
  endfunction

  function automatic int hv(input int a, input int b);
    return (a + b) >>> 1;
  endfunction

  task automatic split(input int p0, input int p1, input int p2, input int p3, output int q [8]);
    int a, b, c, d, e, f;
    a = hv(p0, p1); b = hv(p1, p2); c = hv(p2, p3);
    d = hv(a, b);   e = hv(b, c);   f = hv(d, e);
    q[0] = p0; q[1] = a; q[2] = d; q[3] = f;
    q[4] = f;  q[5] = e; q[6] = c; q[7] = p3;
  endtask

  // de Casteljau midpoint split, u first then v, two guard bits
  task automatic model_compute();
    for (int ax = 0; ax < 3; ax++) begin
      int g [16];
      int u [8][4];
      int vv [8][8];
      int q [8];
      int val;
      for (int k = 0; k < 16; k++) g[k] = sx(m_in[k][ax*CW +: CW]) * 4;
      for (int j = 0; j < 4; j++) begin
        split(g[j], g[4+j], g[8+j], g[12+j], q);
        for (int r = 0; r < 8; r++) u[r][j] = q[r];
      end
      for (int r = 0; r < 8; r++) begin
        split(u[r][0], u[r][1], u[r][2], u[r][3], q);
        for (int c = 0; c < 8; c++) vv[r][c] = q[c];
      end
      for (int s = 0; s < 4; s++)
        for (int i = 0; i < 4; i++)
          for (int j = 0; j < 4; j++) begin
            val = vv[(s/2)*4+i][(s%2)*4+j] >>> 2;
            m_out[s*16+i*4+j][ax*CW +: CW] = val[CW-1:0];
          end
    end
  endtask

  task automatic model_step();
    bit st_ok, w_ok, r_ok, was_busy;
    if (rst) begin
      m_mask = '0; m_ptr = 64; m_busy = 0; m_done = 0; m_valid = 0; m_err = 0; m_data = '0;
    end else begin
      st_ok    = start && !m_busy && (m_mask == 16'hFFFF);
      w_ok     = wr_en && !m_busy && !st_ok;
      r_ok     = rd_en && !m_busy;
      was_busy = m_busy;
      m_valid  = r_ok;
      if (r_ok) begin
        m_done = 0;
        if (m_ptr >= 64) begin m_data = '0; m_err = 1; end
        else begin m_data = m_out[m_ptr]; m_ptr++; end
      end
      if (was_busy) begin
        model_compute();
        m_ptr = 0; m_done = 1; m_err = 0; m_busy = 0;
      end
      if (st_ok) begin
        m_busy = 1; m_mask = '0;
      end else if (w_ok) begin
        m_in[wr_addr]   = wr_data;
        m_mask[wr_addr] = 1'b1;
      end
    end
  endtask

  task automatic chk(input bit ok, input string what, input logic [NW-1:0] act, input logic [NW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(busy === m_busy,     "busy",     NW'(busy),     NW'(m_busy));
    chk(done === m_done,     "done",     NW'(done),     NW'(m_done));
    chk(rd_valid === m_valid, "rd_valid", NW'(rd_valid), NW'(m_valid));
    chk(rd_err === m_err,    "rd_err",   NW'(rd_err),   NW'(m_err));
    chk(rd_data === m_data,  "rd_data",  rd_data,       m_data);
  endtask

  task automatic quiet();
    wr_en = 0; start = 0; rd_en = 0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic put(input int addr, input logic [NW-1:0] d);
    wr_en = 1; wr_addr = addr[3:0]; wr_data = d;
    cyc();
    quiet();
  endtask

  task automatic go();
    start = 1;
    cyc();
    quiet();
  endtask

  task automatic fetch(input int n);
    for (int i = 0; i < n; i++) begin
      rd_en = 1;
      cyc();
    end
    quiet();
  endtask

  function automatic logic [NW-1:0] node(input int x, input int y, input int z);
    logic [CW-1:0] xs, ys, zs;
    xs = x[CW-1:0]; ys = y[CW-1:0]; zs = z[CW-1:0];
    return {zs, ys, xs};
  endfunction

  function automatic logic [NW-1:0] rnd_node();
    logic [31:0] a, b, c;
    a = $urandom; b = $urandom; c = $urandom;
    return {c[CW-1:0], b[CW-1:0], a[CW-1:0]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL %s watchdog actual=running expected=finished", req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    quiet();
    rst = 1;
    req = "R1";
    repeat (3) cyc();
    rst = 0;
    cyc();

    // reads before any result set
    req = "R8";
    fetch(2);

    // incomplete load, address 3 written twice, start ignored
    req = "R3";
    for (int k = 0; k < 15; k++) put(k, node(k * 1024, -k * 100, (k % 4) * 4096 - 3000));
    put(3, node(7777, -1234, 555));
    go();
    cyc();

    // last node completes the net
    req = "R2";
    put(15, node(15 * 1024, -1500, 9000));
    req = "R4";
    go();
    cyc();
    req = "R9";
    repeat (3) cyc();
    req = "R6";
    fetch(32);
    req = "R7";
    fetch(32);
    req = "R8";
    fetch(2);

    // random net including extreme codes
    req = "R5";
    for (int k = 0; k < 16; k++) begin
      if (k == 0)      put(k, node(131071, -131072, 131071));
      else if (k == 5) put(k, node(-131072, 131071, -131072));
      else if (k == 15) put(k, node(-1, 1, -3));
      else             put(k, rnd_node());
    end
    go();
    cyc();
    fetch(10);

    // load the next net while draining, interleaved with reads
    req = "R11";
    for (int k = 0; k < 16; k++) begin
      wr_en = 1; wr_addr = k[3:0]; wr_data = rnd_node(); rd_en = 1;
      cyc();
      quiet();
    end
    fetch(5);

    // start, write and read in one cycle; then read and write in busy cycle
    req = "R10";
    start = 1; rd_en = 1; wr_en = 1; wr_addr = 4'd6; wr_data = node(99, 99, 99);
    cyc();
    quiet();
    rd_en = 1; wr_en = 1; wr_addr = 4'd7; wr_data = node(-5, -5, -5);
    cyc();
    quiet();
    req = "R6";
    fetch(64);
    req = "R8";
    fetch(1);
    req = "R3";
    go();
    cyc();

    // alternating extreme net
    req = "R5";
    for (int k = 0; k < 16; k++)
      put(k, ((k + k / 4) % 2 == 0) ? node(131071, 131071, -131072) : node(-131072, -131072, 131071));
    go();
    cyc();
    fetch(64);
    req = "R8";
    fetch(1);

    // reset in mid-drain
    req = "R1";
    for (int k = 0; k < 16; k++) put(k, rnd_node());
    go();
    cyc();
    fetch(3);
    rst = 1;
    cyc();
    rst = 0;
    cyc();
    fetch(1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule